// File: doc/BRIEF.md
# Push-Button Delta-Sigma LED Dimmer

This block sets the brightness of a single LED from one push button. Holding the button makes an N-bit brightness level climb by one step per slow tick. After its largest value the level rolls over to zero, so holding the button produces a sawtooth. The LED is not driven by a counter-compare PWM. A first-order delta-sigma modulator drives it instead. An error accumulator adds the level on every clock, and the carry out of that addition is the one-bit drive. This spreads the pulses as evenly and as fast as the clock allows.

The LED pin is active-low. A bank of status outputs shows the current level for a limited time after the level last moved, and is dark otherwise. Every register runs on the one system clock. Slow events take a single-cycle enable strobe from a clock divider: the level steps, the debounce counting and the countdown of the display timer. The raw button passes through a two-flop synchronizer. A new button state is accepted only after the input has been stable for a set number of ticks.

Top module: `dsdim_led_dimmer`

## Requirements
- R1: While `rst` is high and on the first clock after it, `led_n` is 1 and `status` is all zeros. The level, the accumulator, the display timer and the debounce state are all cleared.
- R2: With a level of zero, `led_n` never goes low.
- R3: With a constant level L, `led_n` is low in exactly L clocks of every window of 2^LVL_W consecutive clocks. This holds for L = 1, L = 2^(LVL_W-1) and L = 2^LVL_W - 1.
- R4: The drive is active-low: a modulator pulse shows as `led_n` = 0. The drive does not depend on whether the status display is lit.
- R5: While the debounced button is held, the level rises by exactly one on each tick. It wraps from 2^LVL_W - 1 to 0.
- R6: A button pulse shorter than STABLE ticks is ignored. The level does not change and the display timer is not reloaded.
- R7: `status` equals the level while the display timer is nonzero and is all zeros when the timer is zero. The timer counts down by one per tick and stops at zero.
- R8: Each level step reloads the display timer to all ones (2^TMR_W - 1 ticks).
- R9: The divider tick is high for one clock in every DIV clocks and is never high on two clocks in a row.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| btn_raw | input | 1 | Raw push button, high when pressed, asynchronous |
| led_n | output | 1 | Active-low LED drive from the modulator carry |
| status | output | LVL_W | Level display, all zeros when the display timer has expired |

## Verification
A level step reaches `status` one clock after the tick that caused it. The new level then feeds the accumulator on the next clock, and the carry shows on `led_n` one clock after that. The bench therefore never predicts the cycle of a step. It polls `status` at falling edges and uses the value it sees as the expected level. Duty counts start only after the debounced button has dropped and the level has settled. They are always taken over whole windows of 2^LVL_W clocks, which makes the result independent of the accumulator's starting error. Display expiry is checked at tick counts well inside and well past the 2^TMR_W - 1 tick timeout.

// File: rtl/dsdim_pkg.sv
package dsdim_pkg;

    localparam int unsigned LVL_W_DEF  = 8;
    localparam int unsigned TMR_W_DEF  = 6;
    localparam int unsigned DIV_DEF    = 125000;
    localparam int unsigned STABLE_DEF = 4;

    typedef enum logic {
        BTN_RELEASED = 1'b0,
        BTN_HELD     = 1'b1
    } btn_state_e;

    typedef enum logic [1:0] {
        TMR_IDLE   = 2'd0,
        TMR_RELOAD = 2'd1,
        TMR_COUNT  = 2'd2
    } tmr_op_e;

    function automatic tmr_op_e pick_tmr_op(input logic step, input logic tick,
                                            input logic running);
        if (step)
            return TMR_RELOAD;
        else if (tick && running)
            return TMR_COUNT;
        return TMR_IDLE;
    endfunction

endpackage

// File: rtl/dsdim_tick.sv
module dsdim_tick #(
    parameter int unsigned DIV = dsdim_pkg::DIV_DEF
) (
    input  logic clk,
    input  logic rst,
    output logic tick
);
    localparam int unsigned CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

    logic [CNT_W-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt  <= '0;
            tick <= 1'b0;
        end else begin
            tick <= (cnt == CNT_W'(DIV - 1));
            if (cnt == CNT_W'(DIV - 1))
                cnt <= '0;
            else
                cnt <= cnt + 1'b1;
        end
    end

    AST_TICK_SINGLE: assert property (@(posedge clk) disable iff (rst)
        tick |=> !tick); // R9

endmodule

// File: rtl/dsdim_debounce.sv
module dsdim_debounce
    import dsdim_pkg::*;
#(
    parameter int unsigned STABLE = STABLE_DEF
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       tick,
    input  logic       btn_raw,
    output btn_state_e state
);
    localparam int unsigned CNT_W = $clog2(STABLE + 1);

    logic [1:0]       sync;
    logic [CNT_W-1:0] cnt;
    btn_state_e       sampled;

    assign sampled = btn_state_e'(sync[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            sync  <= 2'b00;
            cnt   <= '0;
            state <= BTN_RELEASED;
        end else begin
            sync <= {sync[0], btn_raw};
            if (sampled == state) begin
                cnt <= '0;
            end else if (tick) begin
                if (cnt == CNT_W'(STABLE - 1)) begin
                    state <= sampled;
                    cnt   <= '0;
                end else begin
                    cnt <= cnt + 1'b1;
                end
            end
        end
    end

    AST_DB_ON_TICK: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(state)); // R6

endmodule

// File: rtl/dsdim_modulator.sv
module dsdim_modulator #(
    parameter int unsigned LVL_W = dsdim_pkg::LVL_W_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [LVL_W-1:0] level,
    output logic             pulse
);
    logic [LVL_W-1:0] err;
    logic [LVL_W:0]   sum;

    assign sum = {1'b0, err} + {1'b0, level};

    always_ff @(posedge clk) begin
        if (rst) begin
            err   <= '0;
            pulse <= 1'b0;
        end else begin
            err   <= sum[LVL_W-1:0];
            pulse <= sum[LVL_W];
        end
    end

    AST_ZERO_NO_PULSE: assert property (@(posedge clk) disable iff (rst)
        (level == '0) |=> !pulse); // R2

endmodule

// File: rtl/dsdim_led_dimmer.sv
module dsdim_led_dimmer
    import dsdim_pkg::*;
#(
    parameter int unsigned LVL_W  = LVL_W_DEF,
    parameter int unsigned TMR_W  = TMR_W_DEF,
    parameter int unsigned DIV    = DIV_DEF,
    parameter int unsigned STABLE = STABLE_DEF
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             btn_raw,
    output logic             led_n,
    output logic [LVL_W-1:0] status
);
    logic             tick;
    btn_state_e       btn;
    logic             step;
    logic             pulse;
    logic [LVL_W-1:0] level;
    logic [TMR_W-1:0] timer;
    tmr_op_e          tmr_op;

    dsdim_tick #(.DIV(DIV)) u_tick (
        .clk  (clk),
        .rst  (rst),
        .tick (tick)
    );

    dsdim_debounce #(.STABLE(STABLE)) u_db (
        .clk     (clk),
        .rst     (rst),
        .tick    (tick),
        .btn_raw (btn_raw),
        .state   (btn)
    );

    assign step   = tick && (btn == BTN_HELD);
    assign tmr_op = pick_tmr_op(step, tick, timer != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            level <= '0;
            timer <= '0;
        end else begin
            if (step)
                level <= level + 1'b1;
            unique case (tmr_op)
                TMR_RELOAD: timer <= '1;
                TMR_COUNT:  timer <= timer - 1'b1;
                default:    timer <= timer;
            endcase
        end
    end

    dsdim_modulator #(.LVL_W(LVL_W)) u_mod (
        .clk   (clk),
        .rst   (rst),
        .level (level),
        .pulse (pulse)
    );

    assign led_n  = ~pulse;
    assign status = (timer != '0) ? level : '0;

    AST_LEVEL_STEP: assert property (@(posedge clk) disable iff (rst)
        step |=> level == LVL_W'($past(level) + 1'b1)); // R5
    AST_TIMER_RELOAD: assert property (@(posedge clk) disable iff (rst)
        step |=> timer == '1); // R8
    AST_LEVEL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(level)); // R5
    AST_TIMER_FLOOR: assert property (@(posedge clk) disable iff (rst)
        (timer == '0 && !step) |=> timer == '0); // R7

endmodule

// File: tb/sim_dsdim_led_dimmer.sv
module sim_dsdim_led_dimmer;
    localparam int unsigned LVL_W  = 4;
    localparam int unsigned TMR_W  = 6;
    localparam int unsigned DIV    = 4;
    localparam int unsigned STABLE = 3;
    localparam int unsigned WIN    = 1 << LVL_W;
    localparam int unsigned NVEC   = 4;
    localparam logic [LVL_W-1:0] TARGETS [NVEC] = '{4'd1, 4'd8, 4'd0, 4'd15};

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic             btn_raw = 1'b0;
    logic             led_n;
    logic [LVL_W-1:0] status;

    int  n_tests = 0;
    int  n_fail  = 0;
    bit  done    = 1'b0;
    int  overshoot = 0;

    always #4 clk = ~clk;

    dsdim_led_dimmer #(.LVL_W(LVL_W), .TMR_W(TMR_W), .DIV(DIV), .STABLE(STABLE)) u0 (
        .clk     (clk),
        .rst     (rst),
        .btn_raw (btn_raw),
        .led_n   (led_n),
        .status  (status)
    );

    task automatic check(input string req, input int act, input int exp);
        n_tests++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic count_low(output int n);
        n = 0;
        for (int i = 0; i < int'(WIN); i++) begin
            @(negedge clk);
            if (led_n == 1'b0) n++;
        end
    endtask

    task automatic wait_ticks(input int t);
        repeat (t * DIV) @(negedge clk);
    endtask

    task automatic hold_until(input logic [LVL_W-1:0] val);
        btn_raw = 1'b1;
        for (int i = 0; i < 800; i++) begin
            @(negedge clk);
            if (status == val && i > 8) break;
        end
        btn_raw = 1'b0;
        wait_ticks(STABLE + 4);
    endtask

    initial begin
        int lows;
        logic [LVL_W-1:0] prev, seen, settled;
        repeat (5) @(negedge clk);
        check("R1 status in reset", int'(status), 0);
        check("R1 led_n in reset", int'(led_n), 1);
        rst = 1'b0;
        @(negedge clk);
        check("R1 status after reset", int'(status), 0);
        check("R1 led_n after reset", int'(led_n), 1);

        count_low(lows);
        check("R2 level zero no pulse", lows, 0);

        // R5: ramp with wrap, observed through the display
        btn_raw = 1'b1;
        prev = '0;
        for (int s = 0; s < 20; s++) begin
            seen = prev;
            for (int i = 0; i < 64; i++) begin
                @(negedge clk);
                if (status != prev) begin seen = status; break; end
            end
            check("R5 level step +1 with wrap", int'(seen), int'(LVL_W'(prev + 1'b1)));
            prev = seen;
        end
        btn_raw = 1'b0;
        wait_ticks(STABLE + 4);

        // vector table: settle on each target level, then measure duty
        for (int v = 0; v < int'(NVEC); v++) begin
            hold_until(LVL_W'(int'(TARGETS[v]) - overshoot));
            settled = status;
            if (v == 0) overshoot = int'(settled) - int'(TARGETS[v]);
            count_low(lows);
            check("R3 duty over window", lows, int'(settled));
            count_low(lows);
            check("R3 duty over second window", lows, int'(settled));
            if (settled == '0) check("R2 zero level no pulse", lows, 0);
        end

        // R7: display still lit mid-timeout, blank after it
        check("R7 display shows level", int'(status != '0), 1);
        wait_ticks(80);
        check("R7 display blank after timeout", int'(status), 0);
        count_low(lows);
        check("R4 drive unaffected by blank display", lows, int'(settled));

        // R6: short glitch ignored
        btn_raw = 1'b1;
        repeat (DIV) @(negedge clk);
        btn_raw = 1'b0;
        wait_ticks(20);
        check("R6 glitch no timer reload", int'(status), 0);
        count_low(lows);
        check("R6 glitch level unchanged", lows, int'(settled));

        // R8: each step reloads the full timeout
        btn_raw = 1'b1;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            if (status != '0) break;
        end
        btn_raw = 1'b0;
        wait_ticks(55);
        check("R8 timer reloaded to full", int'(status != '0), 1);
        wait_ticks(45);
        check("R7 display blank after reload expiry", int'(status), 0);

        // R1: reset mid-operation clears level
        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R1 led_n after late reset", int'(led_n), 1);
        count_low(lows);
        check("R1 level cleared by reset", lows, 0);

        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule